// File: doc/BRIEF.md
# Display identification two-wire slave

This block answers reads of a fixed 128-byte display identification table over a two-wire serial bus. It plays the slave role at 7-bit address 0x50. A host first writes one byte to set the word offset. It then issues a repeated START and a read, and the slave returns bytes one after another from that offset. The read pointer advances after every byte and wraps from the last byte back to the first. A read without an offset write continues from wherever the pointer was left.

The table is held in constant logic. It contains:
- the fixed 8-byte header;
- the manufacturer and product codes;
- structure version 1.3 and the basic display parameter bytes;
- unused timing areas;
- one detailed timing descriptor;
- a zero extension flag;
- a final checksum byte that makes all 128 bytes sum to zero modulo 256.

Data bytes written after the offset leave the table and the pointer unchanged and are answered with NACK. The bus lines are oversampled by the system clock. Each line passes through a synchronizer and a glitch filter. START and STOP are then found from SDA edges while SCL is high. SDA is driven open-drain: the output-enable pin pulls the line low, and the data output is held at zero.

Top module: `edid_i2c_slave`

## Requirements
- R1: After reset the slave does not pull SDA low (sda_oe = 0) and the read pointer is 0x00.
- R2: An address byte whose upper seven bits are 0x50 is acknowledged, with SDA pulled low during the ninth clock. Any other address gets no acknowledge, and the slave keeps SDA released until the next START.
- R3: Table bytes read back as follows:
  - 0x00 to 0x07 are 00 FF FF FF FF FF FF 00.
  - 0x08 to 0x0B are 24 94 0D 00.
  - 0x12 to 0x18 are 01 03 80 1E 17 78 0A.
  - 0x23 to 0x25 are 00, and 0x26 to 0x35 are 01.
  - 0x36 to 0x47 are 64 19 00 40 41 00 26 30 18 88 36 00 30 E4 10 00 00 18.
  - 0x7E is 00, and every other byte below 0x7F is 00.
- R4: Byte 0x7F is 0x90, so the sum of all 128 bytes is 0 modulo 256.
- R5: Bytes are sent MSB first. The pointer advances by one after every transmitted byte, whether or not the master acknowledges it. A read with no offset write starts at the current pointer.
- R6: After the byte at 0x7F the pointer wraps to 0x00.
- R7: The byte following a write-direction address is acknowledged and loads the pointer with its low seven bits, so offset 0x88 selects 0x08.
- R8: Data bytes after the offset byte get no acknowledge, and they change neither the table nor the pointer.
- R9: A START while SCL is high restarts the address phase from any state, and an incomplete offset byte then leaves the pointer unchanged. A STOP releases SDA and returns the slave to idle.
- R10: A pulse on SCL shorter than FILT_LEN system clocks (default 3) is ignored and does not count as a bus clock.
- R11: When the master does not acknowledge a read byte, the slave releases SDA and sends nothing more until the next START.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_o | output | 1 | Data value driven when enabled (always 0, open-drain) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
A bus edge reaches the controller after the synchronizer stages, the filter run of FILT_LEN cycles and one edge register. With the defaults this is about seven system clocks, and the slave changes SDA one cycle later. The master in the bench holds every bus phase for a quarter-bit of twelve clocks. It reads SDA in the middle of the SCL high phase, so each acknowledge and data bit has settled before it is sampled. Release of SDA after a NACK or STOP is checked a full quarter-bit after the SCL edge that causes it, which is past the latency of the input path and the controller.

// File: rtl/edid_pkg.sv
package edid_pkg;

    localparam int TABLE_BYTES = 128;
    localparam int TPTR_W      = $clog2(TABLE_BYTES);

    // first detailed timing descriptor, byte 0 in the top bits
    localparam logic [143:0] TIMING_DESC0 =
        144'h6419_0040_4100_2630_1888_3600_30E4_1000_0018;
    localparam logic [6:0] TIMING_DESC0_AT = 7'h36;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_OFS,
        ST_OFS_ACK,
        ST_WDATA,
        ST_TX,
        ST_TX_ACK
    } xfer_state_t;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_ev_t;

    function automatic logic [7:0] desc0_byte(input logic [6:0] k);
        logic [143:0] sh;
        sh = TIMING_DESC0 >> (8 * (17 - int'(k)));
        return sh[7:0];
    endfunction

    // every table byte except the checksum
    function automatic logic [7:0] base_byte(input logic [6:0] a);
        if (a >= 7'h01 && a <= 7'h06) return 8'hFF;
        if (a >= 7'h26 && a <= 7'h35) return 8'h01;
        if (a >= TIMING_DESC0_AT && a <= TIMING_DESC0_AT + 7'd17)
            return desc0_byte(a - TIMING_DESC0_AT);
        case (a)
            7'h08:   return 8'h24;
            7'h09:   return 8'h94;
            7'h0A:   return 8'h0D;
            7'h12:   return 8'h01;
            7'h13:   return 8'h03;
            7'h14:   return 8'h80;
            7'h15:   return 8'h1E;
            7'h16:   return 8'h17;
            7'h17:   return 8'h78;
            7'h18:   return 8'h0A;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] checksum_byte();
        logic [7:0] s;
        s = 8'h00;
        for (int i = 0; i < TABLE_BYTES - 1; i++) s = s + base_byte(7'(i));
        return 8'h00 - s;
    endfunction

endpackage

// File: rtl/i2c_pin_filter.sv
module i2c_pin_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    output logic level_o
);
    localparam int CNT_W = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CNT_W-1:0]       run_cnt;
    logic                   sync_bit;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
    end

    assign sync_bit = sync_q[SYNC_STAGES-1];

    // the level follows only after FILT_LEN consecutive differing samples
    always_ff @(posedge clk) begin
        if (rst) begin
            level_o <= 1'b1;
            run_cnt <= '0;
        end else if (sync_bit == level_o) begin
            run_cnt <= '0;
        end else if (run_cnt == CNT_W'(FILT_LEN - 1)) begin
            level_o <= sync_bit;
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    // R10: a new level is always the one the synchronizer showed just before
    a_r10_follow_sync: assert property (@(posedge clk) disable iff (rst)
        (level_o != $past(level_o)) |-> (level_o == $past(sync_bit)));

endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events
    import edid_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_f,
    input  logic    sda_f,
    output bus_ev_t ev_o
);
    logic scl_d, sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
            ev_o  <= '0;
        end else begin
            scl_d         <= scl_f;
            sda_d         <= sda_f;
            ev_o.scl_rise <= scl_f & ~scl_d;
            ev_o.scl_fall <= ~scl_f & scl_d;
            ev_o.start    <= scl_f & scl_d & sda_d & ~sda_f;
            ev_o.stop     <= scl_f & scl_d & ~sda_d & sda_f;
            ev_o.sda      <= sda_f;
        end
    end

    // R9: START and STOP come from opposite SDA edges and cannot coincide
    a_r9_start_stop_apart: assert property (@(posedge clk) disable iff (rst)
        ev_o.start |-> !ev_o.sda);

endmodule

// File: rtl/edid_table_rom.sv
module edid_table_rom
    import edid_pkg::*;
#(
    parameter int DEPTH = TABLE_BYTES,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    output logic [7:0]    data
);
    logic [7:0] tbl [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_byte
        if (i == DEPTH - 1) begin : g_sum
            assign tbl[i] = checksum_byte();
        end else begin : g_plain
            assign tbl[i] = base_byte(7'(i));
        end
    end

    assign data = tbl[addr];

    // R3: header bytes read out of the generated table
    a_r3_header: assert property (@(posedge clk) disable iff (rst)
        (addr < AW'(8)) |->
        (data == (((addr == AW'(0)) || (addr == AW'(7))) ? 8'h00 : 8'hFF)));

endmodule

// File: rtl/edid_xfer_ctrl.sv
module edid_xfer_ctrl
    import edid_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR = 7'h50,
    parameter int         DEPTH      = TABLE_BYTES,
    localparam int        PW         = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_ev_t       ev,
    input  logic [7:0]    rom_data,
    output logic [PW-1:0] ptr,
    output logic          drive_low
);
    xfer_state_t state;
    logic [3:0]  bitcnt;
    logic [7:0]  shreg;
    logic [7:0]  txreg;
    logic        rw;
    logic        mack;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            bitcnt    <= '0;
            shreg     <= '0;
            txreg     <= '0;
            rw        <= 1'b0;
            mack      <= 1'b0;
            ptr       <= '0;
            drive_low <= 1'b0;
        end else if (ev.start) begin
            state     <= ST_ADDR;
            bitcnt    <= '0;
            drive_low <= 1'b0;
        end else if (ev.stop) begin
            state     <= ST_IDLE;
            drive_low <= 1'b0;
        end else begin
            case (state)
                ST_ADDR: begin
                    if (ev.scl_rise) begin
                        shreg  <= {shreg[6:0], ev.sda};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (ev.scl_fall && bitcnt == 4'd8) begin
                        if (shreg[7:1] == SLAVE_ADDR) begin
                            rw        <= shreg[0];
                            drive_low <= 1'b1;
                            state     <= ST_ADDR_ACK;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (ev.scl_fall) begin
                        bitcnt <= '0;
                        if (rw) begin
                            txreg     <= rom_data;
                            drive_low <= ~rom_data[7];
                            state     <= ST_TX;
                        end else begin
                            drive_low <= 1'b0;
                            state     <= ST_OFS;
                        end
                    end
                end
                ST_OFS: begin
                    if (ev.scl_rise) begin
                        shreg  <= {shreg[6:0], ev.sda};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (ev.scl_fall && bitcnt == 4'd8) begin
                        ptr       <= shreg[PW-1:0];
                        drive_low <= 1'b1;
                        state     <= ST_OFS_ACK;
                    end
                end
                ST_OFS_ACK: begin
                    if (ev.scl_fall) begin
                        drive_low <= 1'b0;
                        bitcnt    <= '0;
                        state     <= ST_WDATA;
                    end
                end
                ST_WDATA: begin
                    // nine clocks per ignored byte, the ninth left unacknowledged
                    if (ev.scl_rise)
                        bitcnt <= (bitcnt == 4'd8) ? 4'd0 : bitcnt + 1'b1;
                end
                ST_TX: begin
                    if (ev.scl_fall) begin
                        if (bitcnt == 4'd7) begin
                            drive_low <= 1'b0;
                            ptr       <= ptr + 1'b1;
                            state     <= ST_TX_ACK;
                        end else begin
                            txreg     <= {txreg[6:0], 1'b0};
                            drive_low <= ~txreg[6];
                            bitcnt    <= bitcnt + 1'b1;
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (ev.scl_rise) begin
                        mack <= ~ev.sda;
                    end else if (ev.scl_fall) begin
                        if (mack) begin
                            txreg     <= rom_data;
                            drive_low <= ~rom_data[7];
                            bitcnt    <= '0;
                            state     <= ST_TX;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R1: idle never holds the line
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !drive_low);

    // R2: a foreign address leaves the acknowledge slot released
    a_r2_foreign_nack: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ADDR && ev.scl_fall && !ev.start && !ev.stop &&
         bitcnt == 4'd8 && shreg[7:1] != SLAVE_ADDR) |=> !drive_low);

    // R5, R6: one step per byte, modulo the table size
    a_r5_ptr_step: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TX && ev.scl_fall && !ev.start && !ev.stop &&
         bitcnt == 4'd7) |=> (ptr == PW'($past(ptr) + 1'b1)));

    // R8: ignored write data is never acknowledged
    a_r8_write_nack: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WDATA) |-> !drive_low);

    // R9: STOP releases and idles
    a_r9_stop_release: assert property (@(posedge clk) disable iff (rst)
        (ev.stop && !ev.start) |=> (state == ST_IDLE && !drive_low));

    // R11: master NACK ends the read
    a_r11_nack_end: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TX_ACK && ev.scl_fall && !ev.start && !ev.stop && !mack)
        |=> (state == ST_IDLE));

endmodule

// File: rtl/edid_i2c_slave.sv
module edid_i2c_slave
    import edid_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR  = 7'h50,
    parameter int         SYNC_STAGES = 2,
    parameter int         FILT_LEN    = 3,
    parameter int         DEPTH       = TABLE_BYTES
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic sda_oe
);
    localparam int PW = $clog2(DEPTH);

    logic [1:0]    raw_pins;
    logic [1:0]    clean_pins;
    bus_ev_t       ev;
    logic [PW-1:0] ptr;
    logic [7:0]    rom_data;
    logic          drive_low;

    assign raw_pins = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_pin
        i2c_pin_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_filt (
            .clk    (clk),
            .rst    (rst),
            .pin_i  (raw_pins[g]),
            .level_o(clean_pins[g])
        );
    end

    i2c_bus_events u_events (
        .clk  (clk),
        .rst  (rst),
        .scl_f(clean_pins[0]),
        .sda_f(clean_pins[1]),
        .ev_o (ev)
    );

    edid_table_rom #(.DEPTH(DEPTH)) u_rom (
        .clk (clk),
        .rst (rst),
        .addr(ptr),
        .data(rom_data)
    );

    edid_xfer_ctrl #(
        .SLAVE_ADDR(SLAVE_ADDR),
        .DEPTH     (DEPTH)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .rom_data (rom_data),
        .ptr      (ptr),
        .drive_low(drive_low)
    );

    assign sda_o  = 1'b0;
    assign sda_oe = drive_low;

endmodule

// File: tb/edid_i2c_slave_bench.sv
module edid_i2c_slave_bench;
    localparam int Q = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_o, sda_oe;
    logic sda_bus;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    assign sda_bus = sda_m & ~(sda_oe & ~sda_o);

    edid_i2c_slave u_edid_i2c_slave (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_m),
        .sda_i (sda_bus),
        .sda_o (sda_o),
        .sda_oe(sda_oe)
    );

    function automatic logic [7:0] exp_byte(input int a);
        logic [7:0] d [18] = '{8'h64, 8'h19, 8'h00, 8'h40, 8'h41, 8'h00,
                               8'h26, 8'h30, 8'h18, 8'h88, 8'h36, 8'h00,
                               8'h30, 8'hE4, 8'h10, 8'h00, 8'h00, 8'h18};
        if (a >= 1 && a <= 6) return 8'hFF;
        if (a >= 'h26 && a <= 'h35) return 8'h01;
        if (a >= 'h36 && a <= 'h47) return d[a - 'h36];
        case (a)
            'h08: return 8'h24;  'h09: return 8'h94;  'h0A: return 8'h0D;
            'h12: return 8'h01;  'h13: return 8'h03;  'h14: return 8'h80;
            'h15: return 8'h1E;  'h16: return 8'h17;  'h17: return 8'h78;
            'h18: return 8'h0A;  'h7F: return 8'h90;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
    endtask

    task automatic wr_bit(input logic b, input logic glitch);
        sda_m = b;
        if (glitch) begin
            wq(Q / 2); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq(Q / 2 - 2);
        end else begin
            wq(Q);
        end
        scl_m = 1'b1; wq(2 * Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic rd_bit(output logic b);
        sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
        b = sda_bus; wq(Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic wr_byte(input logic [7:0] v, input int glitch_at, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) wr_bit(v[i], (7 - i) == glitch_at);
        rd_bit(b);
        ack = ~b;
    endtask

    task automatic rd_byte(input logic last, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin rd_bit(b); v[i] = b; end
        wr_bit(last, 1'b0);
    endtask

    // offset, byte count
    localparam logic [15:0] VEC [6] = '{
        {8'h00, 8'd8}, {8'h08, 8'd4}, {8'h12, 8'd7},
        {8'h23, 8'd3}, {8'h36, 8'd18}, {8'h7C, 8'd6}};

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL WDOG: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] d;
        logic [7:0] sum;
        wq(5);
        rst = 1'b0;
        wq(3);
        check("R1", "oe after reset", {31'd0, sda_oe}, 32'd0);
        // R1: pointer starts at 0x00
        bus_start(); wr_byte(8'hA1, -1, ack);
        check("R2", "ack own read addr", {31'd0, ack}, 32'd1);
        rd_byte(1'b1, d); bus_stop();
        check("R1", "first byte from 0x00", {24'd0, d}, 32'h00);
        wq(Q);
        // R3 R5 R6 vector walk
        for (int v = 0; v < 6; v++) begin
            int ofs;
            int cnt;
            ofs = int'(VEC[v][15:8]);
            cnt = int'(VEC[v][7:0]);
            bus_start(); wr_byte(8'hA0, -1, ack);
            check("R2", "ack own write addr", {31'd0, ack}, 32'd1);
            wr_byte(VEC[v][15:8], -1, ack);
            check("R7", "ack offset", {31'd0, ack}, 32'd1);
            bus_start(); wr_byte(8'hA1, -1, ack);
            check("R2", "ack after restart", {31'd0, ack}, 32'd1);
            for (int k = 0; k < cnt; k++) begin
                rd_byte(k == cnt - 1, d);
                check((ofs + k > 127) ? "R6" : "R3", "table byte", {24'd0, d},
                      {24'd0, exp_byte((ofs + k) % 128)});
            end
            bus_stop(); wq(Q);
        end
        // R5: current-address read continues at 0x02
        bus_start(); wr_byte(8'hA1, -1, ack); rd_byte(1'b1, d); bus_stop();
        check("R5", "current address read", {24'd0, d}, {24'd0, exp_byte(2)});
        // R2: foreign addresses
        bus_start(); wr_byte(8'hA2, -1, ack); bus_stop();
        check("R2", "nack addr 0x51", {31'd0, ack}, 32'd0);
        bus_start(); wr_byte(8'h51, -1, ack); bus_stop();
        check("R2", "nack addr 0x28", {31'd0, ack}, 32'd0);
        check("R2", "released after foreign", {31'd0, sda_oe}, 32'd0);
        // R7: offset high bit dropped
        bus_start(); wr_byte(8'hA0, -1, ack); wr_byte(8'h88, -1, ack);
        bus_start(); wr_byte(8'hA1, -1, ack); rd_byte(1'b1, d); bus_stop();
        check("R7", "offset 0x88 reads 0x08", {24'd0, d}, 32'h24);
        // R8: written data nacked, pointer unchanged
        bus_start(); wr_byte(8'hA0, -1, ack); wr_byte(8'h09, -1, ack);
        wr_byte(8'h55, -1, ack);
        check("R8", "nack data 1", {31'd0, ack}, 32'd0);
        wr_byte(8'hAA, -1, ack);
        check("R8", "nack data 2", {31'd0, ack}, 32'd0);
        bus_stop();
        bus_start(); wr_byte(8'hA1, -1, ack); rd_byte(1'b1, d); bus_stop();
        check("R8", "pointer kept at 0x09", {24'd0, d}, 32'h94);
        // R9: restart inside the offset byte; pointer now 0x0A
        bus_start(); wr_byte(8'hA0, -1, ack);
        wr_bit(1'b1, 1'b0); wr_bit(1'b0, 1'b0); wr_bit(1'b1, 1'b0);
        bus_start(); wr_byte(8'hA1, -1, ack);
        check("R9", "ack after mid-byte restart", {31'd0, ack}, 32'd1);
        rd_byte(1'b1, d);
        check("R11", "released after master nack", {31'd0, sda_oe}, 32'd0);
        bus_stop();
        check("R9", "pointer kept at 0x0A", {24'd0, d}, 32'h0D);
        check("R9", "released after stop", {31'd0, sda_oe}, 32'd0);
        // R10: short SCL pulses inside the offset byte
        bus_start(); wr_byte(8'hA0, -1, ack); wr_byte(8'h14, 1, ack);
        check("R10", "offset ack with glitch", {31'd0, ack}, 32'd1);
        bus_start(); wr_byte(8'hA1, 3, ack); rd_byte(1'b1, d); bus_stop();
        check("R10", "byte at 0x14", {24'd0, d}, 32'h80);
        // R4: whole table sums to zero
        sum = 8'h00;
        bus_start(); wr_byte(8'hA0, -1, ack); wr_byte(8'h00, -1, ack);
        bus_start(); wr_byte(8'hA1, -1, ack);
        for (int k = 0; k < 128; k++) begin
            rd_byte(k == 127, d);
            sum = sum + d;
            if (k == 127) check("R4", "checksum byte", {24'd0, d}, 32'h90);
        end
        check("R11", "released after final nack", {31'd0, sda_oe}, 32'd0);
        bus_stop();
        check("R4", "table sum", {24'd0, sum}, 32'd0);
        summary();
        $finish;
    end

endmodule